// File: doc/BRIEF.md
# PS/2 Port Register Front End

This block is the processor-facing register set of a PS/2 keyboard or mouse port. It sits on a simple 32-bit peripheral bus and decodes a 4 KB window at word granularity. It holds a control register, a clock divisor register, the most recently fetched receive byte, and it observes a receive-pending level. From these it builds a status word, an interrupt identification word and one interrupt output. A fixed set of eight identification bytes sits at the top of the window.

On the receive side, the block works with a PS/2 link layer that has a receive FIFO. The FIFO reports "not empty" on `rx_pending` and shows its head byte on `rx_byte`. A processor read of the data register pops that FIFO for one cycle and keeps the byte. On the transmit side, a processor write of the data register is passed on as a one-cycle strobe that carries the low byte. The serial line protocol, the clock division itself and any device command handling are done elsewhere.

The bus handshake works as follows. A request is one cycle with `bus_sel` high. `bus_wr` selects a write. Read data appears on `bus_rdata` in the cycle after the request, and is zero in every other cycle.

Top module: `ps2_regfront`

## Requirements
- R1: After reset, the control register, divisor register, held receive byte, `irq` and `tx_strobe` are all zero.
- R2: The control register (offset 0x00) and the divisor register (offset 0x0C) are read/write and keep the low CTRL_W and DIV_W bits, default 8. Upper bits read as zero. Read data is valid one cycle after a read request and is zero in cycles with no read request in the previous cycle.
- R3: The status word at offset 0x04 has these fields: bit 6 (transmit empty) always 1; bit 4 (receive full) equal to `rx_pending`; bit 2 equal to the XOR of all 8 bits of the held receive byte. Bits 5, 3, 1, 0 and all other bits read 0.
- R4: A read of offset 0x08 while `rx_pending` is 1 raises `rx_pop` in the request cycle. It loads `rx_byte` into the held byte and returns that byte.
- R5: A read of offset 0x08 while `rx_pending` is 0 leaves `rx_pop` low, keeps the held byte and returns it again.
- R6: A write of offset 0x08 raises `tx_strobe` for exactly the cycle after the request, with `tx_byte` equal to write data bits 7:0.
- R7: `irq` is registered and equals (`rx_pending` AND control bit 4) OR control bit 3. It takes its new value at the clock edge that ends a control write, or at the edge after a change of `rx_pending`.
- R8: The interrupt identification word at offset 0x10 reads `rx_pending` in bit 0 and a constant 1 in bit 1.
- R9: Reads of offsets 0xFE0 to 0xFFC return the identification bytes 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, indexed by (offset-0xFE0)/4.
- R10: Writes to status, interrupt identification or undefined offsets change no register and raise no strobe. Reads of undefined offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| rx_pending | input | 1 | Receive FIFO not empty |
| rx_byte | input | 8 | Receive FIFO head byte |
| rx_pop | output | 1 | Pop the receive FIFO, request cycle |
| tx_strobe | output | 1 | One-cycle transmit byte strobe |
| tx_byte | output | 8 | Byte to transmit |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle. A pop is only issued for a data read while a byte is pending, and the popped byte is captured. The held byte never moves without a pop. The transmit strobe follows exactly the data writes. `irq` matches its enable equation, and idle read data is zero. The status read fields are also checked against pending and the parity of the held byte. Only the bench's scenarios show the rest: the specific values returned, the identification byte contents, the masking of register widths, and that ignored writes leave the control and divisor registers intact.

// File: rtl/ps2rf_pkg.sv
// Package: shared types and constants of the PS/2 register front end.
// Assumes word-aligned offsets; the identification table sits in the top
// 32 bytes of the decoded window.
package ps2rf_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_DATA,
        SEL_DIV,
        SEL_IIR,
        SEL_ID
    } reg_sel_e;

    // Status word bit positions (neighbouring software decodes these)
    localparam int ST_TXEMPTY = 6;
    localparam int ST_TXBUSY  = 5;
    localparam int ST_RXFULL  = 4;
    localparam int ST_RXBUSY  = 3;
    localparam int ST_PARITY  = 2;
    localparam int ST_LINECLK = 1;
    localparam int ST_LINEDAT = 0;

    // Control bits that feed the interrupt
    localparam int CTL_RXIE   = 4;
    localparam int CTL_FORCE  = 3;

    // Identification byte lookup by word index in the ID zone
    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    id_byte = 8'h50;
            3'd1:    id_byte = 8'h10;
            3'd2:    id_byte = 8'h04;
            3'd3:    id_byte = 8'h00;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/ps2rf_decode.sv
// Address decoder: maps a byte offset to a register select and an
// identification byte index. Assumes ADDR_W >= 6. Offsets below 0x20 hold
// the five registers; the top 32 bytes of the window hold the ID table.
module ps2rf_decode
    import ps2rf_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          rsel,
    output logic [2:0]        id_idx
);

    localparam int HI_W = ADDR_W - 5;

    logic [HI_W-1:0] hi;
    logic [2:0]      word;

    assign hi     = addr[ADDR_W-1:5];
    assign word   = addr[4:2];
    assign id_idx = word;

    // Select the target register from the upper and word bits
    always_comb begin
        rsel = SEL_NONE;
        if (hi == '0) begin
            case (word)
                3'd0:    rsel = SEL_CTRL;
                3'd1:    rsel = SEL_STAT;
                3'd2:    rsel = SEL_DATA;
                3'd3:    rsel = SEL_DIV;
                3'd4:    rsel = SEL_IIR;
                default: rsel = SEL_NONE;
            endcase
        end else if (&hi) begin
            rsel = SEL_ID;
        end
    end

endmodule

// File: rtl/ps2rf_regfile.sv
// Register file: control, divisor, held receive byte, receive pop and
// transmit strobe. Assumes the FIFO presents its head byte on rx_byte
// whenever rx_pending is high.
module ps2rf_regfile
    import ps2rf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CTRL_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  reg_sel_e          rsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rx_pending,
    input  logic [7:0]        rx_byte,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [CTRL_W-1:0] ctrl_next,
    output logic [DIV_W-1:0]  div_q,
    output logic [7:0]        last_q,
    output logic              rx_pop,
    output logic              tx_strobe,
    output logic [7:0]        tx_byte
);

    logic wr_ctrl, wr_div, wr_data;

    // Qualify writes per register
    always_comb begin
        wr_ctrl = acc_wr && (rsel == SEL_CTRL);
        wr_div  = acc_wr && (rsel == SEL_DIV);
        wr_data = acc_wr && (rsel == SEL_DATA);
    end

    // Next control value, shared with the interrupt stage
    always_comb ctrl_next = wr_ctrl ? wdata[CTRL_W-1:0] : ctrl_q;

    // Pop the FIFO only for a data read while a byte waits
    always_comb rx_pop = acc_rd && (rsel == SEL_DATA) && rx_pending;

    // Register updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            div_q     <= '0;
            last_q    <= '0;
            tx_strobe <= 1'b0;
            tx_byte   <= '0;
        end else begin
            ctrl_q    <= ctrl_next;
            tx_strobe <= wr_data;
            if (wr_div)  div_q   <= wdata[DIV_W-1:0];
            if (rx_pop)  last_q  <= rx_byte;
            if (wr_data) tx_byte <= wdata[7:0];
        end
    end

endmodule

// File: rtl/ps2rf_irq.sv
// Interrupt stage: registers (pending AND enable) OR force. Uses the
// next control value so a control write takes effect at its own edge.
module ps2rf_irq #(
    parameter int CTRL_W  = 8,
    parameter int IE_BIT  = 4,
    parameter int FRC_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_pending,
    input  logic [CTRL_W-1:0] ctrl_next,
    output logic              irq
);

    // Re-evaluate the interrupt level every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (rx_pending && ctrl_next[IE_BIT]) || ctrl_next[FRC_BIT];
    end

endmodule

// File: rtl/ps2rf_rdmux.sv
// Read path: builds the selected read word and registers it, so data
// appears one cycle after the request and is zero otherwise.
module ps2rf_rdmux
    import ps2rf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CTRL_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  reg_sel_e          rsel,
    input  logic [2:0]        id_idx,
    input  logic [CTRL_W-1:0] ctrl_q,
    input  logic [DIV_W-1:0]  div_q,
    input  logic [7:0]        last_q,
    input  logic              rx_pending,
    input  logic              rx_pop,
    input  logic [7:0]        rx_byte,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] rval;
    logic [7:0]        data_now;

    // Data read returns the freshly popped byte or the held one
    always_comb data_now = rx_pop ? rx_byte : last_q;

    // Select the read word
    always_comb begin
        rval = '0;
        case (rsel)
            SEL_CTRL: rval[CTRL_W-1:0] = ctrl_q;
            SEL_DIV:  rval[DIV_W-1:0]  = div_q;
            SEL_DATA: rval[7:0]        = data_now;
            SEL_STAT: begin
                rval[ST_TXEMPTY] = 1'b1;
                rval[ST_TXBUSY]  = 1'b0;
                rval[ST_RXFULL]  = rx_pending;
                rval[ST_RXBUSY]  = 1'b0;
                rval[ST_PARITY]  = ^last_q;
                rval[ST_LINECLK] = 1'b0;
                rval[ST_LINEDAT] = 1'b0;
            end
            SEL_IIR: begin
                rval[0] = rx_pending;
                rval[1] = 1'b1;
            end
            SEL_ID:   rval[7:0] = id_byte(id_idx);
            default:  rval = '0;
        endcase
    end

    // Register read data; idle cycles return zero
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (acc_rd) rdata <= rval;
        else             rdata <= '0;
    end

endmodule

// File: rtl/ps2_regfront.sv
// Top: PS/2 port register front end. Joins decode, register file,
// interrupt stage and read path. Assumes single-cycle bus requests.
module ps2_regfront
    import ps2rf_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CTRL_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_pending,
    input  logic [7:0]        rx_byte,
    output logic              rx_pop,
    output logic              tx_strobe,
    output logic [7:0]        tx_byte,
    output logic              irq
);

    reg_sel_e          rsel;
    logic [2:0]        id_idx;
    logic              acc_rd, acc_wr;
    logic [CTRL_W-1:0] ctrl_q, ctrl_next;
    logic [DIV_W-1:0]  div_q;
    logic [7:0]        last_q;

    // Split the request into read and write
    always_comb begin
        acc_rd = bus_sel && !bus_wr;
        acc_wr = bus_sel && bus_wr;
    end

    ps2rf_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr   (bus_addr),
        .rsel   (rsel),
        .id_idx (id_idx)
    );

    ps2rf_regfile #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .DIV_W(DIV_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_rd     (acc_rd),
        .acc_wr     (acc_wr),
        .rsel       (rsel),
        .wdata      (bus_wdata),
        .rx_pending (rx_pending),
        .rx_byte    (rx_byte),
        .ctrl_q     (ctrl_q),
        .ctrl_next  (ctrl_next),
        .div_q      (div_q),
        .last_q     (last_q),
        .rx_pop     (rx_pop),
        .tx_strobe  (tx_strobe),
        .tx_byte    (tx_byte)
    );

    ps2rf_irq #(.CTRL_W(CTRL_W), .IE_BIT(CTL_RXIE), .FRC_BIT(CTL_FORCE)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_pending (rx_pending),
        .ctrl_next  (ctrl_next),
        .irq        (irq)
    );

    ps2rf_rdmux #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .DIV_W(DIV_W)) u_rdmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_rd     (acc_rd),
        .rsel       (rsel),
        .id_idx     (id_idx),
        .ctrl_q     (ctrl_q),
        .div_q      (div_q),
        .last_q     (last_q),
        .rx_pending (rx_pending),
        .rx_pop     (rx_pop),
        .rx_byte    (rx_byte),
        .rdata      (bus_rdata)
    );

endmodule

// File: rtl/ps2rf_checker.sv
// Checker: temporal properties of the PS/2 register front end, bound to
// the top. Assumes the default register map offsets.
module ps2rf_checker #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CTRL_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              rx_pending,
    input logic [7:0]        rx_byte,
    input logic              rx_pop,
    input logic              tx_strobe,
    input logic              irq,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic [7:0]        last_q
);

    logic data_acc, stat_rd;
    assign data_acc = bus_sel && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(2));
    assign stat_rd  = bus_sel && !bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));

    assert_pop_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (rx_pending && data_acc && !bus_wr));

    assert_pop_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |=> (last_q == $past(rx_byte)));

    assert_hold_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_pop |=> $stable(last_q));

    assert_tx_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && bus_wr) |=> tx_strobe);

    assert_tx_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_acc && bus_wr) |=> !tx_strobe);

    assert_irq_eq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq == (($past(rx_pending) && ctrl_q[4]) || ctrl_q[3])));

    assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> (bus_rdata == '0));

    assert_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (bus_rdata[6] && (bus_rdata[4] == $past(rx_pending))
                     && (bus_rdata[2] == ^$past(last_q))));

endmodule

bind ps2_regfront ps2rf_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CTRL_W (CTRL_W)
) i_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .rx_pending (rx_pending),
    .rx_byte    (rx_byte),
    .rx_pop     (rx_pop),
    .tx_strobe  (tx_strobe),
    .irq        (irq),
    .ctrl_q     (ctrl_q),
    .last_q     (last_q)
);

// File: tb/test_ps2_regfront.sv
`timescale 1ns/1ps
module test_ps2_regfront;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_pending = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_pop;
    logic        tx_strobe;
    logic [7:0]  tx_byte;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ps2_regfront i_ps2_regfront (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_pending(rx_pending), .rx_byte(rx_byte), .rx_pop(rx_pop),
        .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write: request on one edge; returns at the following negedge
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // Read: samples rx_pop in the request cycle and data after the edge
    task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic pop);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 pop = rx_pop;
        @(posedge clk);
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [7:0] exp_id(input int i);
        logic [7:0] t [8] = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        return t[i];
    endfunction

    task automatic t_reset();
        logic [31:0] d; logic p;
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 tx_strobe", {31'd0, tx_strobe}, 32'd0);
        bus_read(12'h000, d, p); chk("R1 ctrl", d, 32'd0);
        bus_read(12'h00C, d, p); chk("R1 div", d, 32'd0);
        bus_read(12'h008, d, p); chk("R1 last byte", d, 32'd0);
        bus_read(12'h004, d, p); chk("R1 status", d, 32'h40);
    endtask

    task automatic t_ctrl_div();
        logic [31:0] d; logic p;
        bus_write(12'h000, 32'hFFFF_FFA5);
        chk("R2 idle rdata", bus_rdata, 32'd0);
        bus_read(12'h000, d, p); chk("R2 ctrl masked", d, 32'hA5);
        bus_write(12'h00C, 32'h1234_5678);
        bus_read(12'h00C, d, p); chk("R2 div masked", d, 32'h78);
        bus_write(12'h000, 32'h0);
    endtask

    task automatic t_data_read();
        logic [31:0] d; logic p;
        rx_pending = 1'b1; rx_byte = 8'h5A;
        bus_read(12'h008, d, p);
        chk("R4 pop raised", {31'd0, p}, 32'd1);
        chk("R4 popped byte", d, 32'h5A);
        rx_pending = 1'b0; rx_byte = 8'h00;
        bus_read(12'h004, d, p); chk("R3 status even parity", d, 32'h40);
        rx_pending = 1'b1; rx_byte = 8'h07;
        bus_read(12'h004, d, p); chk("R3 status rx full", d, 32'h50);
        bus_read(12'h008, d, p); chk("R4 second byte", d, 32'h07);
        rx_pending = 1'b0;
        bus_read(12'h004, d, p); chk("R3 status odd parity", d, 32'h44);
    endtask

    task automatic t_empty_read();
        logic [31:0] d; logic p;
        rx_pending = 1'b0; rx_byte = 8'hEE;
        bus_read(12'h008, d, p);
        chk("R5 no pop", {31'd0, p}, 32'd0);
        chk("R5 repeat byte", d, 32'h07);
        bus_read(12'h004, d, p); chk("R5 held byte parity", d, 32'h44);
        rx_byte = 8'h00;
    endtask

    task automatic t_iir();
        logic [31:0] d; logic p;
        bus_read(12'h010, d, p); chk("R8 iir idle", d, 32'h2);
        rx_pending = 1'b1; rx_byte = 8'h33;
        bus_read(12'h010, d, p); chk("R8 iir pending", d, 32'h3);
        rx_pending = 1'b0;
    endtask

    task automatic t_irq();
        bus_write(12'h000, 32'h10);
        chk("R7 enabled idle", {31'd0, irq}, 32'd0);
        rx_pending = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R7 rx enable path", {31'd0, irq}, 32'd1);
        rx_pending = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R7 pending drop", {31'd0, irq}, 32'd0);
        bus_write(12'h000, 32'h08);
        chk("R7 force path", {31'd0, irq}, 32'd1);
        bus_write(12'h000, 32'h00);
        chk("R7 force off", {31'd0, irq}, 32'd0);
        rx_pending = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R7 masked pending", {31'd0, irq}, 32'd0);
        rx_pending = 1'b0;
    endtask

    task automatic t_tx();
        bus_write(12'h008, 32'h0000_01C3);
        chk("R6 strobe", {31'd0, tx_strobe}, 32'd1);
        chk("R6 byte", {24'd0, tx_byte}, 32'hC3);
        @(posedge clk); @(negedge clk);
        chk("R6 strobe one cycle", {31'd0, tx_strobe}, 32'd0);
    endtask

    task automatic t_id();
        logic [31:0] d; logic p;
        for (int i = 0; i < 8; i++) begin
            bus_read(12'hFE0 + 12'(i * 4), d, p);
            chk("R9 id byte", d, {24'd0, exp_id(i)});
        end
    endtask

    task automatic t_ignore();
        logic [31:0] d; logic p;
        bus_write(12'h000, 32'h21);
        bus_write(12'h00C, 32'h44);
        bus_write(12'h004, 32'hFF);
        chk("R10 status write no strobe", {31'd0, tx_strobe}, 32'd0);
        bus_write(12'h010, 32'hFF);
        bus_write(12'h100, 32'hFF);
        chk("R10 undefined write no strobe", {31'd0, tx_strobe}, 32'd0);
        bus_write(12'h014, 32'hFF);
        bus_read(12'h000, d, p); chk("R10 ctrl kept", d, 32'h21);
        bus_read(12'h00C, d, p); chk("R10 div kept", d, 32'h44);
        bus_read(12'h100, d, p); chk("R10 undefined read", d, 32'd0);
        bus_read(12'h014, d, p); chk("R10 gap read", d, 32'd0);
        chk("R10 irq unchanged", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_div();
        t_data_read();
        t_empty_read();
        t_iir();
        t_irq();
        t_tx();
        t_id();
        t_ignore();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule